// File: doc/BRIEF.md
# System Exception Control Register Block

This block is the software-visible control surface for the fixed system exceptions of a small processor core. Software writes paired set and clear bits in an exception control/state word to raise or withdraw the non-maskable, pendable-service and system-tick exceptions. The block turns each request into a single-cycle pulse toward an external priority arbiter, which owns the actual pending state. On reads, the same word shows that pending state and the number of the highest-priority pending vector, as the arbiter reports it.

The block also holds the vector table base and the fault-handler enables. It accepts a reset request only when the write carries a 16-bit key. It reports a packed handler status word made of active, pending and enable bits, and it provides a write-only trigger that marks an external interrupt pending by number. Its bus is a simple 32-bit register interface: a write takes effect at the clock edge, and read data is combinational from the current address.

Top module: `sysc_regs`

## Requirements
- R1: A write to offset 0xD04 with bit 31 set produces a one-cycle pulse on `sx_set_o[0]` (non-maskable) in the cycle after the write.
- R2: In a 0xD04 write, bit 28 pulses `sx_set_o[1]` (pendable service). Bit 27 pulses `sx_clr_o[1]` only when bit 28 is 0.
- R3: In a 0xD04 write, bit 26 pulses `sx_set_o[2]` (system tick). Bit 25 pulses `sx_clr_o[2]` only when bit 26 is 0.
- R4: For any exception, a set pulse and a clear pulse never occur in the same cycle. Every pulse lasts exactly one cycle unless it is written again.
- R5: A read of 0xD04 returns the pending state from `sx_pend_i`: bit 31 is non-maskable, bit 28 is pendable service and bit 26 is system tick. Bits 20:12 carry `hi_vec_i` when `hi_vld_i` is 1 and are 0 otherwise.
- R6: Writes to 0xD08 store the data ANDed with 0xFFFFFF80. The stored value is read back at 0xD08 and driven on `vbase_o`.
- R7: A write to 0xD0C with bits 31:16 equal to 0x05FA and bit 2 set produces a one-cycle `rst_req_o` pulse. A write with any other key has no effect.
- R8: A read of 0xD24 packs the active bits from `h_act_i` at these positions: [0] memory fault at bit 0, [1] bus fault at bit 1, [2] usage fault at bit 3, [3] service call at bit 7, [4] debug at bit 8, [5] pendable service at bit 10 and [6] system tick at bit 11. It packs the pending bits from `f_pend_i` as [0] memory at bit 13, [1] bus at bit 14, [2] usage at bit 12 and [3] service call at bit 15. The enables sit at bit 16 (memory), bit 17 (bus) and bit 18 (usage).
- R9: A write to 0xD24 updates only the three fault enables, from bits 16, 17 and 18, which drive `fen_o[0..2]`. The write leaves the vector base untouched and produces no pulses.
- R10: A write to 0xF00 uses bits 8:0 as an interrupt number. It pulses `ext_vld_o` with that number on `ext_num_o` only when the number is below NUM_IRQ (default 64).
- R11: A read of 0x004 returns NUM_IRQ/32 − 1 (1 by default). Reads of unmapped offsets, of write-only offsets, or with `bus_sel` low return 0.
- R12: After reset, all pulse outputs, `vbase_o` and `fen_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| sx_pend_i | input | 3 | Pending state of non-maskable, pendable service and system tick |
| hi_vec_i | input | 9 | Highest pending vector from the arbiter |
| hi_vld_i | input | 1 | `hi_vec_i` is meaningful |
| h_act_i | input | 7 | Handler active flags (see R8) |
| f_pend_i | input | 4 | Fault/service-call pending flags (see R8) |
| sx_set_o | output | 3 | Set-pending pulses |
| sx_clr_o | output | 3 | Clear-pending pulses |
| ext_vld_o | output | 1 | External interrupt trigger pulse |
| ext_num_o | output | 9 | Triggered interrupt number |
| vbase_o | output | 32 | Vector table base |
| fen_o | output | 3 | Fault handler enables: memory, bus, usage |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
The set/clear logic is driven from a table of control words: single set bits, single clear bits, set and clear together for the same exception, mixes that touch all three exceptions at once, and words with only unrelated bits. This separates a correct set-over-clear priority from an inverted or missing one, and it exposes a swapped bit lane. Directed accesses then try keyed resets with good and bad keys and trigger numbers on both sides of the limit. They also drive handler status words with full and sparse input patterns, which catches a misplaced field bit.

// File: rtl/sysc_pkg.sv
// Package: offsets, region indices and bit positions shared by the
// system exception control register block.
package sysc_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int IRQ_W  = 9;

    // Register regions, one hit line each
    localparam int RG_CTYPE  = 0;
    localparam int RG_ICS    = 1;
    localparam int RG_VBASE  = 2;
    localparam int RG_RSTCTL = 3;
    localparam int RG_HSTAT  = 4;
    localparam int RG_SWTRIG = 5;
    localparam int RG_N      = 6;

    // System exception lanes
    localparam int SX_NMI  = 0;
    localparam int SX_PSV  = 1;
    localparam int SX_TICK = 2;
    localparam int SX_N    = 3;

    localparam int ICS_VEC_LSB = 12;
    localparam logic [15:0] RST_KEY = 16'h05FA;
    localparam int RST_REQ_BIT = 2;
    localparam logic [DATA_W-1:0] VBASE_MASK = 32'hFFFF_FF80;
    localparam int HACT_N  = 7;
    localparam int FPEND_N = 4;
    localparam int FEN_N   = 3;
    localparam int FEN_LSB = 16;

    function automatic logic [ADDR_W-1:0] region_ofs(int i);
        case (i)
            RG_CTYPE:  return 12'h004;
            RG_ICS:    return 12'hD04;
            RG_VBASE:  return 12'hD08;
            RG_RSTCTL: return 12'hD0C;
            RG_HSTAT:  return 12'hD24;
            default:   return 12'hF00;
        endcase
    endfunction

    // Bit in the control/state word that raises each exception
    function automatic int set_pos(int i);
        case (i)
            SX_NMI:  return 31;
            SX_PSV:  return 28;
            default: return 26;
        endcase
    endfunction

    // Bit that withdraws each exception (NMI has none)
    function automatic int clr_pos(int i);
        case (i)
            SX_PSV:  return 27;
            default: return 25;
        endcase
    endfunction

    function automatic int act_pos(int i);
        case (i)
            0: return 0;
            1: return 1;
            2: return 3;
            3: return 7;
            4: return 8;
            5: return 10;
            default: return 11;
        endcase
    endfunction

    function automatic int fpend_pos(int i);
        case (i)
            0: return 13;
            1: return 14;
            2: return 12;
            default: return 15;
        endcase
    endfunction
endpackage

// File: rtl/sysc_decode.sv
// Address decoder: one hit line per register region.
// Assumes exact word offsets; any other offset hits nothing.
module sysc_decode
    import sysc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [RG_N-1:0]   hit
);
    for (genvar g = 0; g < RG_N; g++) begin : g_hit
        // compare offset against this region
        assign hit[g] = (addr == region_ofs(g));
    end
endmodule

// File: rtl/sysc_pend_ctl.sv
// Pending control: turns writes to the control/state word and to the
// software trigger into registered one-cycle pulses for the arbiter.
// Assumes write strobes last one cycle per bus access.
module sysc_pend_ctl
    import sysc_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ics_wr,
    input  logic              trig_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [SX_N-1:0]   set_o,
    output logic [SX_N-1:0]   clr_o,
    output logic              ext_vld_o,
    output logic [IRQ_W-1:0]  ext_num_o
);
    localparam logic [IRQ_W:0] LIMIT = (IRQ_W+1)'(NUM_IRQ);

    logic [SX_N-1:0] set_d, clr_d;
    logic [IRQ_W-1:0] num_d;

    for (genvar g = 0; g < SX_N; g++) begin : g_lane
        if (g == SX_NMI) begin : g_noclr
            assign clr_d[g] = 1'b0;
        end else begin : g_clr
            assign clr_d[g] = ics_wr & wdata[clr_pos(g)] & ~wdata[set_pos(g)];
        end
        assign set_d[g] = ics_wr & wdata[set_pos(g)];
    end

    assign num_d = wdata[IRQ_W-1:0];

    // register the pending pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_o <= '0;
            clr_o <= '0;
        end else begin
            set_o <= set_d;
            clr_o <= clr_d;
        end
    end

    // register the software trigger pulse and number
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_vld_o <= 1'b0;
            ext_num_o <= '0;
        end else begin
            ext_vld_o <= trig_wr && ({1'b0, num_d} < LIMIT);
            ext_num_o <= num_d;
        end
    end

    assert_set_clr_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_o & clr_o) == '0);
    assert_set_from_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_o) |-> $past(ics_wr));
    assert_clr_from_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_o) |-> $past(ics_wr));
    assert_trig_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_vld_o |-> ({1'b0, ext_num_o} < LIMIT));
    assert_trig_from_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_vld_o |-> $past(trig_wr));
endmodule

// File: rtl/sysc_cfg_regs.sv
// Configuration state: vector table base, fault enables and the keyed
// reset request pulse. Assumes write strobes are already decoded.
module sysc_cfg_regs
    import sysc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vbase_wr,
    input  logic              rstctl_wr,
    input  logic              hstat_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] vbase_o,
    output logic [FEN_N-1:0]  fen_o,
    output logic              rst_req_o
);
    logic key_ok;
    assign key_ok = (wdata[DATA_W-1:16] == RST_KEY);

    // vector base holds the aligned table address
    always_ff @(posedge clk) begin
        if (!rst_n)        vbase_o <= '0;
        else if (vbase_wr) vbase_o <= wdata & VBASE_MASK;
    end

    // fault enables from the handler status write
    always_ff @(posedge clk) begin
        if (!rst_n)        fen_o <= '0;
        else if (hstat_wr) fen_o <= wdata[FEN_LSB +: FEN_N];
    end

    // reset request pulse on a keyed write
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req_o <= 1'b0;
        else        rst_req_o <= rstctl_wr & key_ok & wdata[RST_REQ_BIT];
    end

    assert_vbase_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vbase_o[6:0] == '0);
    assert_fen_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hstat_wr) |-> $stable(fen_o));
    assert_rst_keyed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> $past(rstctl_wr && wdata[DATA_W-1:16] == RST_KEY));
endmodule

// File: rtl/sysc_regs.sv
// Top: system exception control registers. Decodes the bus, forwards
// writes to the pending and configuration units, and muxes read data.
// Assumes the external arbiter owns all pending/active state.
module sysc_regs
    import sysc_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [2:0]        sx_pend_i,
    input  logic [8:0]        hi_vec_i,
    input  logic              hi_vld_i,
    input  logic [6:0]        h_act_i,
    input  logic [3:0]        f_pend_i,
    output logic [2:0]        sx_set_o,
    output logic [2:0]        sx_clr_o,
    output logic              ext_vld_o,
    output logic [8:0]        ext_num_o,
    output logic [31:0]       vbase_o,
    output logic [2:0]        fen_o,
    output logic              rst_req_o
);
    localparam logic [DATA_W-1:0] CTYPE_VAL = DATA_W'(NUM_IRQ / 32 - 1);

    logic [RG_N-1:0] hit;
    logic [RG_N-1:0] wr_hit;
    logic [DATA_W-1:0] ics_rd, hstat_rd;

    sysc_decode u_dec (.addr(bus_addr), .hit(hit));

    assign wr_hit = hit & {RG_N{bus_sel & bus_wr}};

    sysc_pend_ctl #(.NUM_IRQ(NUM_IRQ)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .ics_wr(wr_hit[RG_ICS]), .trig_wr(wr_hit[RG_SWTRIG]),
        .wdata(bus_wdata),
        .set_o(sx_set_o), .clr_o(sx_clr_o),
        .ext_vld_o(ext_vld_o), .ext_num_o(ext_num_o)
    );

    sysc_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n),
        .vbase_wr(wr_hit[RG_VBASE]), .rstctl_wr(wr_hit[RG_RSTCTL]),
        .hstat_wr(wr_hit[RG_HSTAT]), .wdata(bus_wdata),
        .vbase_o(vbase_o), .fen_o(fen_o), .rst_req_o(rst_req_o)
    );

    // pack the control/state read word
    always_comb begin
        ics_rd = '0;
        for (int i = 0; i < SX_N; i++) ics_rd[set_pos(i)] = sx_pend_i[i];
        if (hi_vld_i) ics_rd[ICS_VEC_LSB +: IRQ_W] = hi_vec_i;
    end

    // pack the handler status read word
    always_comb begin
        hstat_rd = '0;
        for (int i = 0; i < HACT_N; i++)  hstat_rd[act_pos(i)]   = h_act_i[i];
        for (int i = 0; i < FPEND_N; i++) hstat_rd[fpend_pos(i)] = f_pend_i[i];
        hstat_rd[FEN_LSB +: FEN_N] = fen_o;
    end

    // select read data by region
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (1'b1)
                hit[RG_CTYPE]: bus_rdata = CTYPE_VAL;
                hit[RG_ICS]:   bus_rdata = ics_rd;
                hit[RG_VBASE]: bus_rdata = vbase_o;
                hit[RG_HSTAT]: bus_rdata = hstat_rd;
                default:       bus_rdata = '0;
            endcase
        end
    end

    assert_decode_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    assert_idle_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> bus_rdata == '0);
endmodule

// File: tb/sim_sysc_regs.sv
module sim_sysc_regs;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;
    // {write word, expected set {tick,psv,nmi}, expected clr {tick,psv,nmi}}
    localparam logic [37:0] VEC [NV] = '{
        {32'h8000_0000, 3'b001, 3'b000},
        {32'h1000_0000, 3'b010, 3'b000},
        {32'h0800_0000, 3'b000, 3'b010},
        {32'h1800_0000, 3'b010, 3'b000},
        {32'h0400_0000, 3'b100, 3'b000},
        {32'h0200_0000, 3'b000, 3'b100},
        {32'h0600_0000, 3'b100, 3'b000},
        {32'h9A00_0000, 3'b011, 3'b100},
        {32'h0A00_0000, 3'b000, 3'b110},
        {32'h0000_0FFF, 3'b000, 3'b000}
    };

    logic clk = 0, rst_n = 0;
    logic bus_sel = 0, bus_wr = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [2:0] sx_pend_i = '0;
    logic [8:0] hi_vec_i = '0;
    logic hi_vld_i = 0;
    logic [6:0] h_act_i = '0;
    logic [3:0] f_pend_i = '0;
    logic [2:0] sx_set_o, sx_clr_o, fen_o;
    logic ext_vld_o, rst_req_o;
    logic [8:0] ext_num_o;
    logic [31:0] vbase_o;
    int n_chk = 0, n_err = 0;
    logic [31:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysc_regs u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R12 reset state
        @(negedge clk);
        chk({sx_set_o, sx_clr_o, ext_vld_o, rst_req_o} == '0, "R12 pulses", {24'b0, sx_set_o, sx_clr_o, ext_vld_o, rst_req_o}, 0);
        chk(vbase_o == 0 && fen_o == 0, "R12 config", vbase_o | {29'b0, fen_o}, 0);

        // R1 R2 R3 R4 table walk
        for (int i = 0; i < NV; i++) begin
            bus_write(12'hD04, VEC[i][37:6]);
            chk(sx_set_o == VEC[i][5:3], "R1/R2/R3 set", {29'b0, sx_set_o}, {29'b0, VEC[i][5:3]});
            chk(sx_clr_o == VEC[i][2:0], "R2/R3 clr", {29'b0, sx_clr_o}, {29'b0, VEC[i][2:0]});
            @(negedge clk);
            chk(sx_set_o == 0 && sx_clr_o == 0, "R4 one cycle", {26'b0, sx_set_o, 3'b0, sx_clr_o}, 0);
        end

        // R5 control/state read
        sx_pend_i = 3'b111; hi_vec_i = 9'd37; hi_vld_i = 1;
        bus_read(12'hD04, rd);
        chk(rd == 32'h9402_5000, "R5 full", rd, 32'h9402_5000);
        sx_pend_i = 3'b010; hi_vld_i = 0;
        bus_read(12'hD04, rd);
        chk(rd == 32'h1000_0000, "R5 no vector", rd, 32'h1000_0000);

        // R6 vector base
        bus_write(12'hD08, 32'h2000_01FF);
        bus_read(12'hD08, rd);
        chk(rd == 32'h2000_0180, "R6 read", rd, 32'h2000_0180);
        chk(vbase_o == 32'h2000_0180, "R6 port", vbase_o, 32'h2000_0180);

        // R7 keyed reset
        bus_write(12'hD0C, 32'h05FA_0004);
        chk(rst_req_o == 1, "R7 good key", {31'b0, rst_req_o}, 1);
        @(negedge clk);
        chk(rst_req_o == 0, "R7 pulse end", {31'b0, rst_req_o}, 0);
        bus_write(12'hD0C, 32'h05FB_0004);
        chk(rst_req_o == 0, "R7 bad key", {31'b0, rst_req_o}, 0);
        bus_write(12'hD0C, 32'h05FA_0000);
        chk(rst_req_o == 0, "R7 no request bit", {31'b0, rst_req_o}, 0);

        // R9 handler enables
        bus_write(12'hD24, 32'hFFFF_FFFF);
        chk(fen_o == 3'b111 && sx_set_o == 0 && sx_clr_o == 0, "R9 all", {29'b0, fen_o}, 7);
        chk(vbase_o == 32'h2000_0180, "R9 vbase untouched", vbase_o, 32'h2000_0180);
        bus_read(12'hD24, rd);
        chk(rd == 32'h0007_0000, "R8/R9 enables only", rd, 32'h0007_0000);
        bus_write(12'hD24, 32'h0005_0000);
        chk(fen_o == 3'b101, "R9 partial", {29'b0, fen_o}, 5);

        // R8 handler status layout
        h_act_i = '1; f_pend_i = '1;
        bus_read(12'hD24, rd);
        chk(rd == 32'h0005_FD8B, "R8 full", rd, 32'h0005_FD8B);
        h_act_i = 7'b010_0000; f_pend_i = 4'b0100;
        bus_read(12'hD24, rd);
        chk(rd == 32'h0005_1400, "R8 sparse", rd, 32'h0005_1400);
        h_act_i = 7'b001_0001; f_pend_i = 4'b0001;
        bus_read(12'hD24, rd);
        chk(rd == 32'h0005_2101, "R8 mem/debug", rd, 32'h0005_2101);

        // R10 software trigger
        bus_write(12'hF00, 32'd63);
        chk(ext_vld_o == 1 && ext_num_o == 63, "R10 last valid", {22'b0, ext_vld_o, ext_num_o}, {22'b0, 1'b1, 9'd63});
        bus_write(12'hF00, 32'd64);
        chk(ext_vld_o == 0, "R10 at limit", {31'b0, ext_vld_o}, 0);
        bus_write(12'hF00, 32'h0000_01FF);
        chk(ext_vld_o == 0, "R10 max field", {31'b0, ext_vld_o}, 0);
        bus_write(12'hF00, 32'hFFFF_FE05);
        chk(ext_vld_o == 1 && ext_num_o == 5, "R10 upper bits ignored", {22'b0, ext_vld_o, ext_num_o}, {22'b0, 1'b1, 9'd5});

        // R11 type word and unmapped
        bus_read(12'h004, rd);
        chk(rd == 1, "R11 type", rd, 1);
        bus_read(12'h100, rd);
        chk(rd == 0, "R11 unmapped", rd, 0);
        bus_read(12'hF00, rd);
        chk(rd == 0, "R11 write-only", rd, 0);

        // R12 reset clears config again
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        chk(vbase_o == 0 && fen_o == 0, "R12 re-reset", vbase_o | {29'b0, fen_o}, 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule